// File: doc/BRIEF.md
# Interrupt Fatality Classifier

This block collects single-cycle event pulses from two groups, a DMA engine and a bus protocol engine, and holds each one in a sticky status bit. For every pending condition it decides whether the condition is fatal, which stops the script sequencer through a halt request, or nonfatal, which is only recorded. The decision depends on the group the source belongs to, on the source's enable bit, and on the operating mode (initiator or target) that was in force when the event was latched.

The block drives an active-low interrupt request pin behind a global pin mask. The mask only hides the request. Pending state stays in place, so the pin goes low one cycle after the mask is removed. Two summary flags show whether anything is pending in either group. The register bus decode and the sequencer sit outside this block and connect to the status, enable, mask and clear signals directly.

Bus group bit positions (BUS_W is at least 6): 0 function complete, 1 selected, 2 reselected, 3 general-purpose timer expired, 4 handshake timer expired, 5 attention asserted. Bits 6 and up are the error-type sources (parity, bus reset, unexpected disconnect, gross error, phase mismatch, selection timeout, and so on).

Top module: `irq_classifier`

## Requirements
- R1: A pulse on any dma_evt bit sets the matching dma_stat bit at the next clock edge. From that edge on, halt_req is high, because every DMA source is fatal whatever else is set.
- R2: A bus event that is nonfatal in the current mode and whose bus_en bit is 0 sets its bus_stat bit. It leaves halt_req low, and irq_n stays high.
- R3: With tgt_mode=0 (initiator), only bus bits 0 to 4 are nonfatal. Bit 5 and every higher bit are fatal and raise halt_req on the cycle after the event.
- R4: With tgt_mode=1 (target), bus bits 0 to 5 are nonfatal, and bits 6 and up are fatal.
- R5: A pending bus bit whose bus_en bit is 1 counts as fatal. The enable is applied as it currently stands, so setting or clearing the enable changes halt_req on the same cycle.
- R6: Each bus bit's class is captured when the bit goes from clear to set, using the mode at that time. Changing tgt_mode later, or repeating the event while the bit is still set, does not reclassify it.
- R7: While pin_mask is 1, irq_n is high on the following cycle, and all status bits and halt_req are unchanged by the mask.
- R8: At every clock edge, irq_n takes the value NOT(halt_req AND NOT pin_mask) as sampled at that edge. As a result, clearing pin_mask while a fatal condition is pending drives irq_n low one cycle later.
- R9: dma_pend is high exactly when any dma_stat bit is set. bus_pend is high exactly when any bus_stat bit is set.
- R10: Status bits are sticky and clear only on their group's clear strobe (dma_clr or bus_clr). A bit whose event arrives in the same cycle as the clear ends up set.
- R11: After reset, all status bits are 0, both summary flags are 0, halt_req is 0 and irq_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_evt | input | DMA_W | DMA event pulses |
| bus_evt | input | BUS_W | Bus engine event pulses, positions as listed above |
| tgt_mode | input | 1 | 1 = target mode, 0 = initiator mode |
| bus_en | input | BUS_W | Per-source enables for the bus group |
| pin_mask | input | 1 | 1 hides the request at irq_n |
| dma_clr | input | 1 | Clears the DMA status group |
| bus_clr | input | 1 | Clears the bus status group |
| dma_stat | output | DMA_W | Sticky DMA status |
| bus_stat | output | BUS_W | Sticky bus status |
| dma_pend | output | 1 | Any DMA status set |
| bus_pend | output | 1 | Any bus status set |
| irq_n | output | 1 | Active-low interrupt request, registered |
| halt_req | output | 1 | Fatal condition pending, asks the sequencer to stop |

## Verification
An internal fault has two main places to show. A wrongly captured class bit appears as halt_req being wrong on the cycle right after the event. A lost or stuck status bit appears at dma_stat or bus_stat and at the summary flags on that same cycle. Faults in the pin path show up one cycle later at irq_n, because irq_n is registered. The directed part of the bench deliberately holds a condition pending across mode, enable and mask changes. This exposes class bits that were recaptured by mistake and requests that were dropped while masked. A behavioural model compared on every clock then covers random mixes of events and clears.

// File: rtl/irq_classifier.sv
module irq_classifier #(
  parameter int DMA_W = 6,
  parameter int BUS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DMA_W-1:0] dma_evt,
  input  logic [BUS_W-1:0] bus_evt,
  input  logic             tgt_mode,
  input  logic [BUS_W-1:0] bus_en,
  input  logic             pin_mask,
  input  logic             dma_clr,
  input  logic             bus_clr,
  output logic [DMA_W-1:0] dma_stat,
  output logic [BUS_W-1:0] bus_stat,
  output logic             dma_pend,
  output logic             bus_pend,
  output logic             irq_n,
  output logic             halt_req
);
  localparam logic [BUS_W-1:0] NF_INIT = {{(BUS_W-5){1'b0}}, 5'h1F};
  localparam logic [BUS_W-1:0] NF_TGT  = {{(BUS_W-6){1'b0}}, 6'h3F};

  logic [BUS_W-1:0] hard_fatal;
  logic [BUS_W-1:0] bus_keep, capture, nf_now, bus_fatal;
  logic             fatal_pend;

  assign nf_now     = tgt_mode ? NF_TGT : NF_INIT;
  assign bus_keep   = bus_stat & ~{BUS_W{bus_clr}};
  assign capture    = bus_evt & ~bus_keep;
  assign bus_fatal  = bus_stat & (hard_fatal | bus_en);
  assign fatal_pend = (|dma_stat) | (|bus_fatal);

  assign dma_pend = |dma_stat;
  assign bus_pend = |bus_stat;
  assign halt_req = fatal_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_stat   <= '0;
      bus_stat   <= '0;
      hard_fatal <= '0;
      irq_n      <= 1'b1;
    end else begin
      dma_stat   <= dma_evt | (dma_stat & ~{DMA_W{dma_clr}});
      bus_stat   <= bus_evt | bus_keep;
      hard_fatal <= (hard_fatal & ~capture) | (capture & ~nf_now);
      irq_n      <= ~(fatal_pend & ~pin_mask);
    end
  end
endmodule

// File: rtl/irq_classifier_chk.sv
module irq_classifier_chk #(
  parameter int DMA_W = 6,
  parameter int BUS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DMA_W-1:0] dma_evt,
  input logic [BUS_W-1:0] bus_evt,
  input logic             pin_mask,
  input logic             dma_clr,
  input logic [DMA_W-1:0] dma_stat,
  input logic             bus_pend,
  input logic             irq_n,
  input logic             halt_req
);
  AST_DMA_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (|dma_evt) |=> halt_req); // R1
  AST_IDLE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !halt_req |=> irq_n); // R2
  AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    pin_mask |=> irq_n); // R7
  AST_UNMASK_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && !pin_mask) |=> !irq_n); // R8
  AST_BUS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_evt) |=> bus_pend); // R9
  AST_DMA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_clr |=> ((dma_stat & $past(dma_stat)) == $past(dma_stat))); // R10
endmodule

bind irq_classifier irq_classifier_chk #(.DMA_W(DMA_W), .BUS_W(BUS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .dma_evt(dma_evt), .bus_evt(bus_evt),
  .pin_mask(pin_mask), .dma_clr(dma_clr), .dma_stat(dma_stat),
  .bus_pend(bus_pend), .irq_n(irq_n), .halt_req(halt_req)
);

// File: tb/irq_classifier_tb_top.sv
`timescale 1ns/1ps
module irq_classifier_tb_top;
  localparam int DW = 6;
  localparam int BW = 12;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_n = 0;
  logic [DW-1:0] dma_evt = '0;
  logic [BW-1:0] bus_evt = '0, bus_en = '0;
  logic tgt_mode = 0, pin_mask = 0, dma_clr = 0, bus_clr = 0;
  logic [DW-1:0] dma_stat;
  logic [BW-1:0] bus_stat;
  logic dma_pend, bus_pend, irq_n, halt_req;

  int checks = 0, fails = 0;
  bit done = 0;

  bit m_d [DW];
  bit m_b [BW];
  bit m_hf[BW];
  bit m_irq_n = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_classifier #(.DMA_W(DW), .BUS_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dma_evt(dma_evt), .bus_evt(bus_evt),
    .tgt_mode(tgt_mode), .bus_en(bus_en), .pin_mask(pin_mask),
    .dma_clr(dma_clr), .bus_clr(bus_clr), .dma_stat(dma_stat),
    .bus_stat(bus_stat), .dma_pend(dma_pend), .bus_pend(bus_pend),
    .irq_n(irq_n), .halt_req(halt_req));

  function automatic bit m_fatal();
    bit f = 0;
    for (int i = 0; i < DW; i++) f |= m_d[i];
    for (int i = 0; i < BW; i++) f |= m_b[i] & (m_hf[i] | bus_en[i]);
    return f;
  endfunction

  function automatic bit nonfatal_class(int i, bit tgt);
    return (i < 5) || (tgt && i == 5);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DW; i++) m_d[i] = 0;
      for (int i = 0; i < BW; i++) begin m_b[i] = 0; m_hf[i] = 0; end
      m_irq_n = 1;
    end else begin
      m_irq_n = !(m_fatal() && !pin_mask);
      for (int i = 0; i < DW; i++)
        if (dma_evt[i]) m_d[i] = 1; else if (dma_clr) m_d[i] = 0;
      for (int i = 0; i < BW; i++) begin
        if (bus_evt[i]) begin
          if (!m_b[i] || bus_clr) m_hf[i] = !nonfatal_class(i, tgt_mode);
          m_b[i] = 1;
        end else if (bus_clr) m_b[i] = 0;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    logic [DW-1:0] ed; logic [BW-1:0] eb;
    for (int i = 0; i < DW; i++) ed[i] = m_d[i];
    for (int i = 0; i < BW; i++) eb[i] = m_b[i];
    chk("R1 dma_stat", 32'(dma_stat), 32'(ed));
    chk("R10 bus_stat", 32'(bus_stat), 32'(eb));
    chk("R9 dma_pend", 32'(dma_pend), 32'(|ed));
    chk("R9 bus_pend", 32'(bus_pend), 32'(|eb));
    chk("R3 halt_req", 32'(halt_req), 32'(m_fatal()));
    chk("R8 irq_n", 32'(irq_n), 32'(m_irq_n));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic pulse_bus(int b);
    bus_evt[b] = 1; tick(); bus_evt = '0;
  endtask

  task automatic clear_all();
    dma_clr = 1; bus_clr = 1; tick(); dma_clr = 0; bus_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 stat", 32'({dma_stat, bus_stat}), 32'h0);
    chk("R11 pins", 32'({irq_n, halt_req, dma_pend, bus_pend}), 32'b1000);

    pulse_bus(0);
    chk("R2 halt", 32'(halt_req), 0);
    tick();
    chk("R2 irq_n", 32'(irq_n), 1);
    chk("R2 stat", 32'(bus_stat), 32'h001);
    clear_all();

    pulse_bus(6);
    chk("R3 bit6 fatal", 32'(halt_req), 1);
    tick();
    chk("R3 irq low", 32'(irq_n), 0);
    clear_all();
    pulse_bus(5);
    chk("R3 attn fatal initiator", 32'(halt_req), 1);
    clear_all(); tick();

    tgt_mode = 1;
    pulse_bus(5);
    chk("R4 attn nonfatal target", 32'(halt_req), 0);
    bus_en[5] = 1; #1;
    chk("R5 enable makes fatal", 32'(halt_req), 1);
    bus_en[5] = 0; #1;
    chk("R5 enable removed", 32'(halt_req), 0);
    tgt_mode = 0; tick();
    chk("R6 no reclass on mode change", 32'(halt_req), 0);
    pulse_bus(5);
    chk("R6 repeat event keeps class", 32'(halt_req), 0);
    clear_all();
    tgt_mode = 1;
    pulse_bus(8);
    chk("R4 bit8 fatal target", 32'(halt_req), 1);
    tgt_mode = 0; tick();
    chk("R6 fatal kept", 32'(halt_req), 1);
    clear_all(); tick();

    pin_mask = 1;
    dma_evt[1] = 1; tick(); dma_evt = '0;
    chk("R1 dma halts", 32'(halt_req), 1);
    repeat (3) tick();
    chk("R7 pin hidden", 32'(irq_n), 1);
    chk("R7 status kept", 32'(dma_stat), 32'h02);
    pin_mask = 0; tick();
    chk("R8 unmask asserts", 32'(irq_n), 0);

    dma_evt[2] = 1; dma_clr = 1; tick(); dma_evt = '0; dma_clr = 0;
    chk("R10 event beats clear", 32'(dma_stat), 32'h04);
    clear_all();

    for (int n = 0; n < 3000; n++) begin
      dma_evt  = ($urandom % 8 == 0) ? DW'(1 << ($urandom % DW)) : '0;
      bus_evt  = ($urandom % 4 == 0) ? BW'(1 << ($urandom % BW)) : '0;
      dma_clr  = ($urandom % 16 == 0);
      bus_clr  = ($urandom % 16 == 0);
      if ($urandom % 32 == 0) tgt_mode = ~tgt_mode;
      if ($urandom % 32 == 0) pin_mask = ~pin_mask;
      if ($urandom % 64 == 0) bus_en = BW'($urandom) & BW'($urandom);
      tick();
    end
    dma_evt = '0; bus_evt = '0; dma_clr = 0; bus_clr = 0;
    tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule